// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator

This block drives one leg of a switching power stage. It takes a single switching command bit and produces two gate-enable outputs, one for the upper device and one for the lower device. Every time the command changes, both enables are held off for a programmable guard interval before the newly selected device is turned on. A shoot-through path from supply to ground can therefore not be requested by the logic, even when the command toggles quickly.

The guard interval is picked from eight fixed settings by a three-bit select code. The code is captured while reset is held and frozen when reset is released, so the pins can be shared or left floating during operation. The settings are fixed durations in picoseconds, converted at elaboration time into tick counts of the fast clock through the `TICK_PS` parameter and rounded to the nearest tick. A global drive-enable input turns both gates off on the next clock edge, with no guard interval.

Top module: `nonoverlap_gen`

## Requirements
- R1: While `rst` is sampled high, and after the first clock edge that samples it high, both `gate_hi` and `gate_lo` are low.
- R2: `dt_sel` is stored on every edge that samples `rst` high. The value present at the last such edge sets the guard interval until the next reset. Changes on `dt_sel` while `rst` is low have no effect on the outputs.
- R3: With the default `TICK_PS` = 1500, select codes 0 to 7 give guard intervals of 41, 33, 25, 16, 10, 9, 8 and 6 clock cycles. These are 62, 49, 37, 24, 15, 13.5, 12 and 9 ns rounded to the nearest tick.
- R4: When the first edge samples `sw_cmd` different from the side currently selected, both enables are low after that edge for exactly N cycles, where N is the guard interval. After that, `gate_hi` goes high if `sw_cmd` is 1, or `gate_lo` goes high if it is 0.
- R5: If `sw_cmd` changes again before the guard interval ends, the interval restarts from the edge that sees the change. Both enables stay low for a full N cycles from that edge.
- R6: `gate_hi` and `gate_lo` are never high in the same cycle.
- R7: After the first edge that samples `drive_en` low, both enables are low with no delay. After `drive_en` returns high, both stay low for a full N cycles before either turns on.
- R8: After reset is released with `drive_en` high, both enables stay low for N cycles before the side chosen by `sw_cmd` is first enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast tick clock |
| rst | input | 1 | Synchronous active-high reset; select code is captured while high |
| drive_en | input | 1 | Global enable; low forces both gates off |
| sw_cmd | input | 1 | Switching command: 1 selects upper device, 0 lower device |
| dt_sel | input | 3 | Guard interval select code |
| gate_hi | output | 1 | Upper device gate enable |
| gate_lo | output | 1 | Lower device gate enable |

## Verification
The bench builds the block with the default `TICK_PS` of 1500. This makes all eight guard intervals 6 to 41 cycles, so each setting can be measured to the exact cycle within a few dozen clocks. Because the intervals are short, random command toggles often land inside the guard window, which exercises the restart rule. Random drive-enable drops and random mid-run resets with new codes also occur often over a few thousand cycles.

// File: rtl/nog_pkg.sv
package nog_pkg;

    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 1 << SEL_W;

    typedef enum logic [1:0] {
        LEG_IDLE  = 2'd0,
        LEG_GUARD = 2'd1,
        LEG_DRIVE = 2'd2
    } leg_state_e;

    typedef struct packed {
        leg_state_e st;
        logic       side;   // 1: upper device, 0: lower device
    } leg_ctl_t;

    // Guard duration in picoseconds for each select code.
    function automatic int unsigned guard_ps(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 62000;
            3'd1:    return 49000;
            3'd2:    return 37000;
            3'd3:    return 24000;
            3'd4:    return 15000;
            3'd5:    return 13500;
            3'd6:    return 12000;
            default: return 9000;
        endcase
    endfunction

    // Round to nearest tick, never below one tick.
    function automatic int unsigned guard_ticks(input logic [SEL_W-1:0] sel,
                                                input int unsigned tick_ps);
        int unsigned t;
        t = (guard_ps(sel) + tick_ps / 2) / tick_ps;
        if (t < 1) t = 1;
        return t;
    endfunction

endpackage

// File: rtl/nog_sel_capture.sv
module nog_sel_capture
    import nog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] sel_q
);
    // Track the pins only during reset; the last value before release sticks.
    always_ff @(posedge clk) begin
        if (rst) sel_q <= sel_in;
    end
endmodule

// File: rtl/nog_tick_lut.sv
module nog_tick_lut
    import nog_pkg::*;
#(
    parameter int unsigned TICK_PS = 1500,
    parameter int          CNT_W   = 6
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] ticks
);
    logic [CNT_W-1:0] tbl [NUM_CODES];

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_entry
        assign tbl[i] = CNT_W'(guard_ticks(SEL_W'(i), TICK_PS));
    end

    assign ticks = tbl[sel];
endmodule

// File: rtl/nog_leg_fsm.sv
module nog_leg_fsm
    import nog_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drive_en,
    input  logic             sw_cmd,
    input  logic [CNT_W-1:0] need,
    output logic             gate_hi,
    output logic             gate_lo
);
    leg_ctl_t         ctl;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !drive_en) begin
            ctl.st   <= LEG_IDLE;
            ctl.side <= 1'b0;
            cnt      <= '0;
        end else if (ctl.st == LEG_IDLE || sw_cmd != ctl.side) begin
            // New target (or re-toggle): start a full guard interval.
            ctl.st   <= LEG_GUARD;
            ctl.side <= sw_cmd;
            cnt      <= need - CNT_W'(1);
        end else if (ctl.st == LEG_GUARD) begin
            if (cnt == '0) ctl.st <= LEG_DRIVE;
            else           cnt    <= cnt - CNT_W'(1);
        end
    end

    assign gate_hi = (ctl.st == LEG_DRIVE) &&  ctl.side;
    assign gate_lo = (ctl.st == LEG_DRIVE) && !ctl.side;
endmodule

// File: rtl/nonoverlap_gen.sv
module nonoverlap_gen
    import nog_pkg::*;
#(
    parameter int unsigned TICK_PS = 1500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       drive_en,
    input  logic       sw_cmd,
    input  logic [2:0] dt_sel,
    output logic       gate_hi,
    output logic       gate_lo
);
    localparam int unsigned MAX_TICKS = guard_ticks(SEL_W'(0), TICK_PS);
    localparam int          CNT_W     = $clog2(MAX_TICKS + 1);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] need;

    nog_sel_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .sel_in (dt_sel),
        .sel_q  (sel_q)
    );

    nog_tick_lut #(.TICK_PS(TICK_PS), .CNT_W(CNT_W)) u_lut (
        .sel   (sel_q),
        .ticks (need)
    );

    nog_leg_fsm #(.CNT_W(CNT_W)) u_leg (
        .clk      (clk),
        .rst      (rst),
        .drive_en (drive_en),
        .sw_cmd   (sw_cmd),
        .need     (need),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );
endmodule

// File: rtl/nonoverlap_gen_chk.sv
module nonoverlap_gen_chk
    import nog_pkg::*;
#(
    parameter int unsigned TICK_PS = 1500
) (
    input logic       clk,
    input logic       rst,
    input logic       drive_en,
    input logic       sw_cmd,
    input logic [2:0] dt_sel,
    input logic       gate_hi,
    input logic       gate_lo
);
    logic [2:0]  code_seen;
    logic [15:0] off_run;
    int unsigned need_chk;

    // Independent record of the code and of the consecutive all-off run.
    always_ff @(posedge clk) begin
        if (rst) begin
            code_seen <= dt_sel;
            off_run   <= '0;
        end else if (!gate_hi && !gate_lo) begin
            if (off_run != 16'hFFFF) off_run <= off_run + 16'd1;
        end else begin
            off_run <= '0;
        end
    end

    assign need_chk = guard_ticks(code_seen, TICK_PS);

    AST_NEVER_BOTH_ON: assert property (@(posedge clk)
        !(gate_hi && gate_lo)); // R6

    AST_RESET_OFF: assert property (@(posedge clk)
        rst |=> (!gate_hi && !gate_lo)); // R1

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        !drive_en |=> (!gate_hi && !gate_lo)); // R7

    AST_GUARD_BEFORE_HI: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> (32'(off_run) >= need_chk)); // R4

    AST_GUARD_BEFORE_LO: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> (32'(off_run) >= need_chk)); // R5

    AST_HI_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> $past(sw_cmd)); // R4
endmodule

bind nonoverlap_gen nonoverlap_gen_chk #(.TICK_PS(TICK_PS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .drive_en (drive_en),
    .sw_cmd   (sw_cmd),
    .dt_sel   (dt_sel),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
);

// File: tb/nonoverlap_gen_bench.sv
module nonoverlap_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       drive_en = 1'b0;
    logic       sw_cmd = 1'b0;
    logic [2:0] dt_sel = 3'd0;
    logic       gate_hi, gate_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    nonoverlap_gen u_nonoverlap_gen (
        .clk(clk), .rst(rst), .drive_en(drive_en), .sw_cmd(sw_cmd),
        .dt_sel(dt_sel), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    function automatic int exp_ticks(input logic [2:0] c);
        case (c)
            3'd0: return 41; 3'd1: return 33; 3'd2: return 25; 3'd3: return 16;
            3'd4: return 10; 3'd5: return 9;  3'd6: return 8;  default: return 6;
        endcase
    endfunction

    // Reference model built from the requirements.
    logic [2:0] m_code = 3'd0;
    bit m_act = 0, m_side = 0;
    int m_run = 0;
    always @(posedge clk) begin
        if (rst) m_code = dt_sel;
        if (rst || !drive_en) m_act = 0;
        else if (!m_act || sw_cmd != m_side) begin
            m_act = 1; m_side = sw_cmd; m_run = 0;
        end else m_run++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            automatic bit on = m_act && (m_run >= exp_ticks(m_code));
            check({tag, " gate_hi"}, int'(gate_hi), int'(on && m_side));
            check({tag, " gate_lo"}, int'(gate_lo), int'(on && !m_side));
            check("R6 both on", int'(gate_hi && gate_lo), 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts negedge samples with both gates low until one turns on.
    task automatic count_off(output int n);
        n = 0;
        @(negedge clk);
        while (!gate_hi && !gate_lo && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst = 1; drive_en = 1; dt_sel = code;
        cyc(2);
        rst = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int n;
        tag = "R1";
        cyc(3);
        check("R1 reset hi", int'(gate_hi), 0);
        check("R1 reset lo", int'(gate_lo), 0);

        for (int c = 0; c < 8; c++) begin
            tag = "R3";
            sw_cmd = 0;
            do_reset(3'(c));
            count_off(n);
            check("R8 release guard", n, exp_ticks(3'(c)));
            check("R4 low side on", int'(gate_lo), 1);
            dt_sel = 3'(7 - c);          // ignored outside reset
            cyc(3);
            sw_cmd = 1;
            count_off(n);
            check("R3 guard ticks", n, exp_ticks(3'(c)));
            check("R4 high side on", int'(gate_hi), 1);
            cyc(2);
            sw_cmd = 0;
            count_off(n);
            check("R2 code pins ignored", n, exp_ticks(3'(c)));
            check("R4 low side back", int'(gate_lo), 1);
        end

        // R5: re-toggle inside the guard window restarts it.
        tag = "R5";
        sw_cmd = 0;
        do_reset(3'd3);
        count_off(n);
        sw_cmd = 1;
        cyc(5);
        sw_cmd = 0;
        count_off(n);
        check("R5 restart guard", n, 16);
        check("R5 low side after restart", int'(gate_lo), 1);

        // R7: drive-enable drop and return.
        tag = "R7";
        drive_en = 0;
        cyc(1);
        check("R7 off after disable hi", int'(gate_hi), 0);
        check("R7 off after disable lo", int'(gate_lo), 0);
        cyc(4);
        drive_en = 1;
        count_off(n);
        check("R7 full guard on enable", n, 16);

        // Random phase, fixed seed.
        tag = "R4 random";
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) begin
                do_reset(3'($urandom_range(0, 7)));
            end else if (r < 10) begin
                drive_en = ~drive_en;
                if (!drive_en) begin
                    cyc(1);
                    check("R7 random disable", int'(gate_hi || gate_lo), 0);
                end
            end else begin
                sw_cmd = ~sw_cmd;
                dt_sel = 3'($urandom_range(0, 7));
            end
            cyc($urandom_range(1, 50));
            drive_en = drive_en | ($urandom_range(0, 3) == 0);
        end

        cyc(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule